// File: doc/BRIEF.md
# DMA Transmit Block Request Sequencer

This block paces DMA write cycles into a serial transmitter that holds only a 32-byte transmit buffer. Software loads a 12-bit frame byte count through a high register (upper 4 bits) and a low register (lower 8 bits), then issues a start command. The frame length is the programmed count plus one, so any length from 1 to 4096 bytes can be sent.

After the start command the block raises its DMA request line. The DMA controller answers with byte writes, one per strobe. The block forwards each accepted byte to the transmitter and counts it against the current burst size. A burst is 32 bytes, or the leftover bytes for the last burst of a frame. When a burst completes, the block signals the transmitter and drops the request. If more bytes remain, it waits in a drain state until the transmitter pulses its buffer-free event, then requests the next burst. The last burst is tagged end of message.

The control is a three-state machine:
- States: `ST_IDLE`, `ST_BURST` and `ST_DRAIN`.
- Transitions:
  - IDLE→BURST on an accepted start.
  - BURST→DRAIN on the last write of a burst that is not final.
  - BURST→IDLE on the last write of the final burst.
  - DRAIN→BURST on a buffer-free pulse.

Top module: `dma_tx_burst_seq`

## Requirements
- R1: A write strobe on `cnt_hi_we` loads `cfg_wdata[3:0]` as count bits 11..8. A write strobe on `cnt_lo_we` loads `cfg_wdata[7:0]` as count bits 7..0. The frame length is the count plus one.
- R2: A `start` while `busy` is low moves the block to BURST. `busy` and `dma_req` are high from the next cycle, and `busy` stays high until the frame ends.
- R3: The burst sizes of a frame are as many 32-byte bursts as fit, then one burst of (length mod 32) bytes if that is nonzero. A count of 69 gives bursts of 32, 32 and 6.
- R4: `dma_req` is high only in BURST. It falls in the cycle after the last write of a burst is accepted.
- R5: `tx_wr` pulses only for a `dma_wr` seen while `dma_req` is high, and `tx_wdata` then equals `dma_wdata`. A strobe at any other time is ignored.
- R6: After a non-final burst, `dma_req` stays low until a `pool_ready` pulse arrives in DRAIN. A `pool_ready` pulse in IDLE or BURST has no effect.
- R7: `burst_end` pulses with the last accepted write of each burst. `burst_eom` pulses with it only for the final burst, after which `busy` falls. A frame whose length is a multiple of 32 ends with a tagged 32-byte burst and no empty burst.
- R8: A `start` while `busy` is high does not disturb the frame in progress. It sets `start_err`, which stays high until reset.
- R9: A synchronous `rst` returns the block to IDLE with `dma_req`, `busy` and `start_err` low and the count registers at zero.
- R10: Count register writes made during a frame do not change that frame's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_hi_we | input | 1 | Write strobe for the count high register |
| cnt_lo_we | input | 1 | Write strobe for the count low register |
| cfg_wdata | input | 8 | Data for the count register writes |
| start | input | 1 | Start-of-frame command |
| dma_wr | input | 1 | DMA write strobe, one byte per strobe |
| dma_wdata | input | 8 | DMA write data |
| pool_ready | input | 1 | Pulse from the transmitter: buffer drained |
| dma_req | output | 1 | DMA request line |
| tx_wr | output | 1 | Byte write into the transmit buffer |
| tx_wdata | output | 8 | Byte written into the transmit buffer |
| burst_end | output | 1 | Burst complete, hand the buffer to the transmitter |
| burst_eom | output | 1 | The completed burst ends the message |
| busy | output | 1 | Frame in progress |
| start_err | output | 1 | Sticky flag: start issued while busy |

## Verification
Frames are sent with several counts, each chosen to separate one possible fault:
- 69 gives the 32/32/6 split.
- 0 gives a single one-byte burst.
- 31 and 63 give lengths that are exact multiples of 32, which exposes an extra empty burst or a misplaced end-of-message tag.
- 0x3A5 needs both count registers to be decoded correctly.
- 4095 gives the largest frame, which exposes carry and width faults in the remaining-byte count.

DMA strobes arrive in three patterns: every cycle, two cycles out of three, and one cycle out of five. These tell apart counting strobes from counting request cycles, and also test that strobes made during drain are ignored. The drain wait varies from zero to several cycles, which checks the request hold-off.

One frame is disturbed with all of the following, to test the error flag and count latching:
- a stray buffer-free pulse during a burst,
- a start while the frame is busy,
- a count register write.

A reset in the middle of a frame tests the return to idle.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_t;
endpackage

// File: rtl/dmaseq_count_regs.sv
module dmaseq_count_regs #(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);
    localparam int HI_W = CNT_W - DATA_W;

    logic [HI_W-1:0]   hi_q;
    logic [DATA_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (hi_we) hi_q <= wdata[HI_W-1:0];
            if (lo_we) lo_q <= wdata;
        end
    end

    assign count = {hi_q, lo_q};
endmodule

// File: rtl/dmaseq_burst_size.sv
module dmaseq_burst_size #(
    parameter int REM_W      = 13,
    parameter int POOL_BYTES = 32,
    parameter int SZ_W       = 6
) (
    input  logic [REM_W-1:0] remaining,
    output logic [SZ_W-1:0]  size,
    output logic             last
);
    always_comb begin
        last = (remaining <= REM_W'(POOL_BYTES));
        size = last ? remaining[SZ_W-1:0] : SZ_W'(POOL_BYTES);
    end
endmodule

// File: rtl/dmaseq_beat_ctr.sv
module dmaseq_beat_ctr #(
    parameter int SZ_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            inc,
    input  logic [SZ_W-1:0] size,
    output logic            last_beat
);
    logic [SZ_W-1:0] beat_q;

    assign last_beat = ((beat_q + SZ_W'(1)) == size);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            beat_q <= '0;
        end else if (inc) begin
            beat_q <= last_beat ? '0 : beat_q + SZ_W'(1);
        end
    end
endmodule

// File: rtl/dma_tx_burst_seq.sv
module dma_tx_burst_seq
    import dmaseq_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int DATA_W     = 8,
    parameter int POOL_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_hi_we,
    input  logic              cnt_lo_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              start,
    input  logic              dma_wr,
    input  logic [DATA_W-1:0] dma_wdata,
    input  logic              pool_ready,
    output logic              dma_req,
    output logic              tx_wr,
    output logic [DATA_W-1:0] tx_wdata,
    output logic              burst_end,
    output logic              burst_eom,
    output logic              busy,
    output logic              start_err
);
    localparam int REM_W = CNT_W + 1;
    localparam int SZ_W  = $clog2(POOL_BYTES) + 1;

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] count;
    logic [REM_W-1:0] remaining_q;
    logic [SZ_W-1:0]  burst_sz;
    logic             final_burst;
    logic             last_beat;
    logic             start_ok;

    dmaseq_count_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .hi_we (cnt_hi_we),
        .lo_we (cnt_lo_we),
        .wdata (cfg_wdata),
        .count (count)
    );

    dmaseq_burst_size #(.REM_W(REM_W), .POOL_BYTES(POOL_BYTES), .SZ_W(SZ_W)) u_size (
        .remaining (remaining_q),
        .size      (burst_sz),
        .last      (final_burst)
    );

    dmaseq_beat_ctr #(.SZ_W(SZ_W)) u_beat (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_ok),
        .inc       (tx_wr),
        .size      (burst_sz),
        .last_beat (last_beat)
    );

    assign start_ok = start && (state_q == ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_BURST;
            ST_BURST: if (burst_end) state_d = final_burst ? ST_IDLE : ST_DRAIN;
            ST_DRAIN: if (pool_ready) state_d = ST_BURST;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        dma_req = 1'b0;
        busy    = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin dma_req = 1'b0; busy = 1'b0; end
            ST_BURST: begin dma_req = 1'b1; busy = 1'b1; end
            ST_DRAIN: begin dma_req = 1'b0; busy = 1'b1; end
            default:  begin dma_req = 1'b0; busy = 1'b0; end
        endcase
        tx_wr     = dma_req && dma_wr;
        tx_wdata  = dma_wdata;
        burst_end = tx_wr && last_beat;
        burst_eom = burst_end && final_burst;
    end

    // Bytes left in the frame and sticky error
    always_ff @(posedge clk) begin
        if (rst) begin
            remaining_q <= '0;
            start_err   <= 1'b0;
        end else begin
            if (start_ok)
                remaining_q <= {1'b0, count} + REM_W'(1);
            else if (burst_end)
                remaining_q <= remaining_q - REM_W'(burst_sz);
            if (start && (state_q != ST_IDLE))
                start_err <= 1'b1;
        end
    end
endmodule

// File: rtl/dmaseq_checker.sv
module dmaseq_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic pool_ready,
    input logic dma_req,
    input logic tx_wr,
    input logic burst_end,
    input logic burst_eom,
    input logic busy,
    input logic start_err
);
    assert_req_busy_R4: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> busy);

    assert_req_drop_R4: assert property (@(posedge clk) disable iff (rst)
        burst_end |=> !dma_req);

    assert_wr_gated_R5: assert property (@(posedge clk) disable iff (rst)
        tx_wr |-> dma_req);

    assert_drain_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !dma_req && !pool_ready) |=> !dma_req);

    assert_eom_pair_R7: assert property (@(posedge clk) disable iff (rst)
        burst_eom |-> burst_end);

    assert_eom_idle_R7: assert property (@(posedge clk) disable iff (rst)
        burst_eom |=> !busy);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && dma_req));

    assert_err_set_R8: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> start_err);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        start_err |=> start_err);

    assert_reset_idle_R9: assert property (@(posedge clk)
        rst |=> (!busy && !dma_req && !start_err));
endmodule

bind dma_tx_burst_seq dmaseq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pool_ready (pool_ready),
    .dma_req    (dma_req),
    .tx_wr      (tx_wr),
    .burst_end  (burst_end),
    .burst_eom  (burst_eom),
    .busy       (busy),
    .start_err  (start_err)
);

// File: tb/tb_dma_tx_burst_seq.sv
module tb_dma_tx_burst_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_hi_we = 1'b0, cnt_lo_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       start = 1'b0, dma_wr = 1'b0, pool_ready = 1'b0;
    logic [7:0] dma_wdata = '0;
    logic       dma_req, tx_wr, burst_end, burst_eom, busy, start_err;
    logic [7:0] tx_wdata;

    always #10 clk = ~clk;

    dma_tx_burst_seq dut (
        .clk(clk), .rst(rst), .cnt_hi_we(cnt_hi_we), .cnt_lo_we(cnt_lo_we),
        .cfg_wdata(cfg_wdata), .start(start), .dma_wr(dma_wr), .dma_wdata(dma_wdata),
        .pool_ready(pool_ready), .dma_req(dma_req), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .burst_end(burst_end), .burst_eom(burst_eom), .busy(busy), .start_err(start_err)
    );

    int checks = 0, errors = 0, cycles = 0;
    // reference model state: 0 idle, 1 burst, 2 drain
    int m_state = 0, m_hi = 0, m_lo = 0, m_rem = 0, m_beat = 0;
    bit m_err = 0;
    int cur_len = 0, eom_seen = 0;
    int got_q[$];

    task automatic chk(string tag, string nm, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %b exp %b at cycle %0d", tag, nm, got, exp, cycles);
        end
    endtask

    task automatic chk_int(string tag, string nm, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d exp %0d", tag, nm, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // one clock: compare outputs against model, then advance the model
    task automatic tick();
        int  sz, cnt_old;
        bit  e_req, e_wr, e_end, e_eom, e_busy;
        sz     = (m_rem > 32) ? 32 : m_rem;
        e_req  = (m_state == 1);
        e_wr   = e_req && dma_wr;
        e_end  = e_wr && (m_beat + 1 == sz);
        e_eom  = e_end && (m_rem <= 32);
        e_busy = (m_state != 0);
        #1;
        chk("R2", "busy", busy, e_busy);
        chk("R4", "dma_req", dma_req, e_req);
        chk("R5", "tx_wr", tx_wr, e_wr);
        if (e_wr) chk_int("R5", "tx_wdata", int'(tx_wdata), int'(dma_wdata));
        chk("R6", "burst_end", burst_end, e_end);
        chk("R7", "burst_eom", burst_eom, e_eom);
        chk("R8", "start_err", start_err, m_err);
        if (tx_wr) cur_len++;
        if (burst_end) begin
            got_q.push_back(cur_len);
            cur_len = 0;
            if (burst_eom) eom_seen++;
        end
        @(posedge clk);
        cnt_old = m_hi * 256 + m_lo;
        if (rst) begin
            m_state = 0; m_hi = 0; m_lo = 0; m_rem = 0; m_beat = 0; m_err = 0;
        end else begin
            if (cnt_hi_we) m_hi = cfg_wdata & 15;
            if (cnt_lo_we) m_lo = cfg_wdata;
            case (m_state)
                0: if (start) begin m_rem = cnt_old + 1; m_beat = 0; m_state = 1; end
                1: begin
                    if (start) m_err = 1;
                    if (e_wr) begin
                        if (e_end) begin
                            m_rem = m_rem - sz; m_beat = 0;
                            m_state = e_eom ? 0 : 2;
                        end else m_beat++;
                    end
                end
                default: begin
                    if (start) m_err = 1;
                    if (pool_ready) m_state = 1;
                end
            endcase
        end
        @(negedge clk);
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    endtask

    task automatic program_count(int cnt);
        cnt_hi_we = 1; cfg_wdata = 8'((cnt >> 8) | 8'hF0); tick(); // upper nibble ignored (R1)
        cnt_hi_we = 0; cnt_lo_we = 1; cfg_wdata = 8'(cnt & 255); tick();
        cnt_lo_we = 0;
    endtask

    // mode: 0 strobe every cycle, 1 two of three, 2 one of five
    task automatic run_frame(string tag, int cnt, int mode, int drain_dly, bit poke);
        int len, k, dcnt, nb;
        got_q.delete(); cur_len = 0; eom_seen = 0;
        program_count(cnt);
        start = 1; tick(); start = 0;
        k = 0; dcnt = 0;
        while (m_state != 0) begin
            case (mode)
                0: dma_wr = 1'b1;
                1: dma_wr = (k % 3) != 1;
                default: dma_wr = (k % 5) == 0;
            endcase
            dma_wdata  = 8'(k * 7 + 3);
            pool_ready = (m_state == 2) && (dcnt >= drain_dly);
            if (poke) begin
                if (k == 3) pool_ready = 1'b1;   // stray pulse during burst (R6)
                start     = (k == 5);            // start while busy (R8)
                cnt_lo_we = (k == 9);            // count write mid-frame (R10)
                cfg_wdata = 8'h02;
            end
            dcnt = (m_state == 2) ? dcnt + 1 : 0;
            tick();
            k++;
        end
        dma_wr = 0; pool_ready = 0; start = 0; cnt_lo_we = 0;
        len = cnt + 1;
        nb = len / 32 + ((len % 32) != 0 ? 1 : 0);
        chk_int(tag, "burst count", got_q.size(), nb);
        for (int i = 0; i < got_q.size(); i++)
            chk_int(tag, "burst size", got_q[i], (i < len / 32) ? 32 : len % 32);
        chk_int("R7", "eom bursts", eom_seen, 1);
        // strobes and buffer-free pulses after the frame are ignored (R5, R6)
        dma_wr = 1; pool_ready = 1; tick(); tick();
        dma_wr = 0; pool_ready = 0;
        chk("R5", "idle after frame", dma_req, 1'b0);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        tick();  // reset held, model at reset state
        rst = 0;
        chk("R9", "reset dma_req", dma_req, 1'b0);
        chk("R9", "reset busy", busy, 1'b0);
        chk("R9", "reset start_err", start_err, 1'b0);

        run_frame("R3", 69, 0, 4, 0);
        run_frame("R3", 0, 1, 2, 0);
        run_frame("R7", 63, 1, 0, 0);
        run_frame("R7", 31, 2, 3, 0);
        run_frame("R1", 12'h3A5, 2, 2, 0);
        run_frame("R3", 4095, 0, 1, 0);
        run_frame("R10", 40, 1, 3, 1);
        chk("R8", "sticky after frame", start_err, 1'b1);
        chk_int("R10", "low reg written mid-frame", m_lo, 2);

        // reset in the middle of a frame (R9)
        program_count(100);
        start = 1; tick(); start = 0;
        dma_wr = 1;
        for (int i = 0; i < 10; i++) tick();
        rst = 1; tick(); rst = 0; dma_wr = 0;
        chk("R9", "midframe reset busy", busy, 1'b0);
        chk("R9", "midframe reset req", dma_req, 1'b0);
        chk("R9", "midframe reset err", start_err, 1'b0);
        // count registers cleared: a start now sends one byte (R9, R1)
        got_q.delete(); cur_len = 0;
        start = 1; tick(); start = 0;
        dma_wr = 1; tick(); tick(); dma_wr = 0;
        chk_int("R9", "post-reset frame bursts", got_q.size(), 1);
        if (got_q.size() == 1) chk_int("R9", "post-reset frame size", got_q[0], 1);

        run_frame("R3", 5, 0, 0, 0);
        finish_run();
    end
endmodule